// File: doc/BRIEF.md
# Timer register bank with indirect DMA burst window

This block holds the software-visible registers of a general-purpose timer and serves them on a simple word-addressed bus. A bus access names a word index; each word sits four bytes above the previous one. The counter, compare and waveform logic that consume these registers lie outside the block, as does the DMA engine.

Besides direct access, one fixed word (byte offset 0x4C) acts as a window. It stores nothing. Each access to it is steered to a timer register chosen by a base index plus an internal pointer. The pointer then moves on by one. After the programmed number of transfers it returns to the base. A burst control word (byte offset 0x48) sets the base and the length. A DMA engine therefore moves a run of consecutive registers by hitting one address repeatedly. The block asks for each next transfer on a level request line. The request is raised by an external update event and re-raised by every window access that does not close the burst.

The pointer is driven by a two-state machine. In `ST_IDLE` no request is pending. In `ST_REQ` the request line is high. There are four named transitions:
- `BCTL_WR`: a burst control write, which returns the machine to `ST_IDLE` from either state.
- `ADVANCE`: a window access that does not close the burst, which enters `ST_REQ`.
- `WRAP`: the window access that closes the burst, which enters `ST_IDLE`.
- `UPDATE`: an update event, which enters `ST_REQ`.

Their priority follows that order.

Top module: `tmr_regfile_dma`

## Requirements
- R1: After reset, every register reads 0, `dma_req` is 0 and `bus_rdata` is 0.
- R2: Writes keep only the implemented bits. Word 0 (control, byte offset 0x00) keeps bits 9:0, so writing 0x01345678 reads back 0x00000278. Word 11 and words 13 to 16 keep all 32 bits.
- R3: The burst control word at byte offset 0x48 holds the base index in bits 4:0 and the length field in bits 12:8. Its other bits read 0, so writing 0xFFFFFFFF reads back 0x00001F1F.
- R4: An access to the window (byte offset 0x4C) reads or writes the register at index base + pointer. That register is the same storage that direct access reaches.
- R5: The pointer advances by one on every window access, whether the access is a read or a write.
- R6: A length field of N gives N+1 transfers. The access made when the pointer equals N returns the pointer to the base.
- R7: A window access that does not wrap sets `dma_req` to 1 on the next cycle. A wrapping access sets it to 0.
- R8: `dma_req` stays at its level until the next window access or burst control write.
- R9: A one-cycle `update_evt` pulse sets `dma_req` to 1. A window access or burst control write in the same cycle takes priority over it.
- R10: A write to the burst control word resets the pointer to the base and clears `dma_req`.
- R11: The following read 0 and ignore writes: words 5, 12 and 17, and words 20 to 31. A window target that lands on any of these, or on word 18 or word 19, behaves the same way.
- R12: Read data is registered. It appears on the cycle after a read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| update_evt | input | 1 | Timer update event that starts a burst |
| dma_req | output | 1 | Level request for the next DMA transfer |

## Verification
Every result of this block is due exactly one clock edge after the access or event that causes it. This holds for the read data, the new pointer position (seen through the next window read), and the level of `dma_req`. No result takes longer, because the path from input to output never passes more than one register. The bench drives each access at a falling edge and removes it at the next falling edge. It samples `bus_rdata` and `dma_req` at that second falling edge, half a cycle after the edge that updated them. Hold checks for R8 and R12 repeat the sample after further idle or write cycles.

// File: rtl/tmr_rf_pkg.sv
package tmr_rf_pkg;

    // Word indices with fixed meaning
    localparam int CTRL_IDX = 0;
    localparam int BCTL_IDX = 18;
    localparam int WIN_IDX  = 19;
    // Registers at or above this index have no plain storage
    localparam int NREG     = 18;
    // Bit position of the burst length field in the burst control word
    localparam int LEN_LSB  = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } win_state_e;

    // Implemented-bit mask of each plain register; zero marks a hole
    function automatic logic [31:0] reg_mask(input int idx);
        logic [31:0] m;
        unique case (idx)
            0:                  m = 32'h0000_03FF;
            1:                  m = 32'h0000_00F8;
            2:                  m = 32'h0000_FFF7;
            3:                  m = 32'h0000_5F5F;
            4:                  m = 32'h0000_1E5F;
            6, 7:               m = 32'h0000_FFFF;
            8:                  m = 32'h0000_3333;
            9, 11, 13, 14, 15, 16: m = 32'hFFFF_FFFF;
            10:                 m = 32'h0000_FFFF;
            default:            m = 32'h0000_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr_reg_store.sv
module tmr_reg_store
    import tmr_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int SEL_W = $clog2(NREG);

    logic [DATA_W-1:0] q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = DATA_W'(reg_mask(gi));
        if (MASK == '0) begin : g_hole
            assign q[gi] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (wr_en && wr_idx == TIDX_W'(gi)) begin
                    r <= wr_data & MASK;
                end
            end
            assign q[gi] = r;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx < TIDX_W'(NREG)) begin
            rd_data = q[rd_idx[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/tmr_win_ptr.sv
module tmr_win_ptr
    import tmr_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 5,
    parameter int TIDX_W = FLD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bctl_wr,
    input  logic [DATA_W-1:0] bctl_wdata,
    input  logic              win_acc,
    input  logic              update_evt,
    output logic [TIDX_W-1:0] tgt_idx,
    output logic [DATA_W-1:0] bctl_rd,
    output logic              dma_req
);

    win_state_e        state, state_nx;
    logic [FLD_W-1:0]  base_q, len_q, cnt_q;
    logic              wrap;

    assign wrap = win_acc && (cnt_q == len_q);

    // Next-state logic: BCTL_WR > ADVANCE/WRAP > UPDATE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (bctl_wr)         state_nx = ST_IDLE;
                else if (win_acc)    state_nx = wrap ? ST_IDLE : ST_REQ;
                else if (update_evt) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (bctl_wr)         state_nx = ST_IDLE;
                else if (win_acc)    state_nx = wrap ? ST_IDLE : ST_REQ;
            end
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        dma_req = (state == ST_REQ);
    end

    // Burst configuration and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else if (bctl_wr) begin
            base_q <= bctl_wdata[FLD_W-1:0];
            len_q  <= bctl_wdata[LEN_LSB +: FLD_W];
            cnt_q  <= '0;
        end else if (win_acc) begin
            cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign tgt_idx = TIDX_W'(base_q) + TIDX_W'(cnt_q);

    always_comb begin
        bctl_rd = '0;
        bctl_rd[FLD_W-1:0]         = base_q;
        bctl_rd[LEN_LSB +: FLD_W]  = len_q;
    end

    // R10
    bctl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bctl_wr |=> (cnt_q == '0 && !dma_req));

    // R7
    advance_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !bctl_wr && cnt_q != len_q) |=> dma_req);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !bctl_wr && cnt_q == len_q) |=> (cnt_q == '0 && !dma_req));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !bctl_wr && cnt_q != len_q) |=> cnt_q == FLD_W'($past(cnt_q) + 1'b1));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !win_acc && !bctl_wr) |=> dma_req);

    // R9
    update_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update_evt && !win_acc && !bctl_wr) |=> dma_req);

endmodule

// File: rtl/tmr_regfile_dma.sv
module tmr_regfile_dma
    import tmr_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int FLD_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              update_evt,
    output logic              dma_req
);

    localparam int TIDX_W = FLD_W + 1;

    logic              at_win, at_bctl;
    logic              win_acc, bctl_wr, rd_acc;
    logic [TIDX_W-1:0] win_tgt, tgt_idx;
    logic [DATA_W-1:0] st_rd, bctl_rd, rd_val;

    assign at_win  = (bus_addr == ADDR_W'(WIN_IDX));
    assign at_bctl = (bus_addr == ADDR_W'(BCTL_IDX));
    assign win_acc = bus_sel && at_win;
    assign bctl_wr = bus_sel && bus_wr && at_bctl;
    assign rd_acc  = bus_sel && !bus_wr;
    assign tgt_idx = at_win ? win_tgt : TIDX_W'(bus_addr);

    tmr_win_ptr #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .TIDX_W (TIDX_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bctl_wr    (bctl_wr),
        .bctl_wdata (bus_wdata),
        .win_acc    (win_acc),
        .update_evt (update_evt),
        .tgt_idx    (win_tgt),
        .bctl_rd    (bctl_rd),
        .dma_req    (dma_req)
    );

    tmr_reg_store #(
        .DATA_W (DATA_W),
        .TIDX_W (TIDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_sel && bus_wr),
        .wr_idx  (tgt_idx),
        .wr_data (bus_wdata),
        .rd_idx  (tgt_idx),
        .rd_data (st_rd)
    );

    assign rd_val = at_bctl ? bctl_rd : st_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_val;
    end

    // R11
    hole_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr > ADDR_W'(WIN_IDX)) |=> bus_rdata == '0);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));

endmodule

// File: tb/tmr_regfile_dma_bench.sv
`timescale 1ns/1ps
module tmr_regfile_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        update_evt = 1'b0;
    logic        dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_CTRL = 5'd0;
    localparam logic [4:0] A_BCTL = 5'd18;
    localparam logic [4:0] A_WIN  = 5'd19;

    always #10 clk = ~clk;

    tmr_regfile_dma u_tmr_regfile_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .update_evt (update_evt),
        .dma_req    (dma_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [31:0] exp);
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic chk_req(input string tag, input logic exp);
        chk(dma_req === exp, tag, {31'b0, dma_req}, {31'b0, exp});
    endtask

    // One bus cycle; results are valid on return
    task automatic bus_op(input logic wr, input logic [4:0] a, input logic [31:0] d, input logic upd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; update_evt = upd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; update_evt = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_op(1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [4:0] a);
        bus_op(1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_rd("R1 rdata after reset", 32'h0);
        chk_req("R1 dma_req after reset", 1'b0);
        rd(A_CTRL);  chk_rd("R1 control word after reset", 32'h0);
        rd(A_BCTL);  chk_rd("R1 burst control after reset", 32'h0);
        rd(5'd13);   chk_rd("R1 compare word after reset", 32'h0);
    endtask

    task automatic t_mask;
        wr(A_CTRL, 32'h0134_5678);
        rd(A_CTRL);  chk_rd("R2 control keeps bits 9:0", 32'h0000_0278);
        wr(5'd13, 32'hDEAD_BEEF);
        rd(5'd13);   chk_rd("R2 full-width word", 32'hDEAD_BEEF);
        wr(A_CTRL, 32'h0000_0000);
        chk_rd("R12 rdata held across write", 32'hDEAD_BEEF);
        wr(A_CTRL, 32'h0134_5678);
    endtask

    task automatic t_hole;
        wr(5'd12, 32'hFFFF_FFFF);
        rd(5'd12);   chk_rd("R11 hole word 12", 32'h0);
        wr(5'd25, 32'hFFFF_FFFF);
        rd(5'd25);   chk_rd("R11 word 25 beyond window", 32'h0);
    endtask

    task automatic t_alias;
        rd(A_WIN);   chk_rd("R4 window aliases control word", 32'h0000_0278);
        chk_req("R7 single-transfer burst wraps, no request", 1'b0);
        wr(A_WIN, 32'h0000_03FF);
        rd(A_CTRL);  chk_rd("R4 window write lands in control word", 32'h0000_03FF);
    endtask

    task automatic t_bctl_fields;
        wr(A_BCTL, 32'hFFFF_FFFF);
        rd(A_BCTL);  chk_rd("R3 burst control field mask", 32'h0000_1F1F);
        wr(A_BCTL, 32'h0000_020D);
        rd(A_BCTL);  chk_rd("R3 base 13 length 2", 32'h0000_020D);
    endtask

    task automatic t_burst;
        wr(5'd13, 32'hAAAA_0001);
        wr(5'd14, 32'hBBBB_0002);
        wr(5'd15, 32'hCCCC_0003);
        wr(A_BCTL, 32'h0000_020D);
        chk_req("R10 request clear after burst control write", 1'b0);
        rd(A_WIN);   chk_rd("R4 first burst transfer", 32'hAAAA_0001);
        chk_req("R7 request after first transfer", 1'b1);
        idle(3);
        chk_req("R8 request held while idle", 1'b1);
        rd(A_WIN);   chk_rd("R5 pointer advanced to second", 32'hBBBB_0002);
        chk_req("R7 request after second transfer", 1'b1);
        rd(A_WIN);   chk_rd("R5 pointer advanced to third", 32'hCCCC_0003);
        chk_req("R7 request dropped on wrap", 1'b0);
        rd(A_WIN);   chk_rd("R6 pointer wrapped to base", 32'hAAAA_0001);
        idle(2);
        chk_req("R8 request still held", 1'b1);
    endtask

    task automatic t_win_write;
        wr(A_BCTL, 32'h0000_010D);
        wr(A_WIN, 32'h0000_0011);
        chk_req("R7 request after window write", 1'b1);
        wr(A_WIN, 32'h0000_0022);
        chk_req("R6 wrap after two writes", 1'b0);
        rd(5'd13);   chk_rd("R5 first window write target", 32'h0000_0011);
        rd(5'd14);   chk_rd("R5 second window write target", 32'h0000_0022);
    endtask

    task automatic t_update;
        wr(A_BCTL, 32'h0000_000D);
        bus_op(1'b0, A_WIN, 32'h0, 1'b1);
        chk_req("R9 wrapping access beats update event", 1'b0);
        bus_op(1'b0, 5'd0, 32'h0, 1'b1);
        chk_req("R9 update event raises request", 1'b1);
        wr(A_BCTL, 32'h0000_020D);
        chk_req("R10 burst control write clears request", 1'b0);
        rd(A_WIN);
        rd(A_WIN);   chk_rd("R5 second transfer before reset", 32'h0000_0022);
        wr(A_BCTL, 32'h0000_020D);
        rd(A_WIN);   chk_rd("R10 pointer back to base", 32'h0000_0011);
    endtask

    task automatic t_win_hole;
        wr(A_BCTL, 32'h0000_0211);
        wr(A_WIN, 32'hFFFF_FFFF);
        wr(A_WIN, 32'hFFFF_FFFF);
        rd(A_WIN);   chk_rd("R11 window on window word reads zero", 32'h0);
        rd(A_WIN);   chk_rd("R11 window on hole word 17 reads zero", 32'h0);
        rd(A_BCTL);  chk_rd("R11 window write to burst control ignored", 32'h0000_0211);
        rd(5'd17);   chk_rd("R11 hole word 17 ignored window write", 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_mask;
        t_hole;
        t_alias;
        t_bctl_fields;
        t_burst;
        t_win_write;
        t_update;
        t_win_hole;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule